// File: doc/BRIEF.md
# Configuration Upset Criticality Classifier

This block sits behind a configuration-memory scrubber. Each time the scrubber finds a flipped configuration bit it hands over an error report: the frame index and the bit offset inside that frame. The classifier decides how much that upset matters and what should be done about it.

The upper bits of the frame index select a region, so one region covers a fixed group of frames. A synchronous region map gives each region an 8-bit criticality class. Class 0 marks the region as unused, and such an error is dropped without any response. Any other class indexes an action table, which gives a 2-bit recovery code for that class. The lookup runs in two steps: one cycle reads the region map and the next reads the action table. The input handshake is held off while a lookup is in progress. A write port fills both tables. Two saturating counters count the dropped errors and the errors that were acted on.

Top module: `seu_class_lookup`

## Requirements
- R1: After reset, err_ready is 1, rsp_valid is 0, and both counters are 0.
- R2: The region map address is err_frame[FRAME_W-1 -: REGION_W] (default frame bits 11:4). The lower frame bits and err_offset have no effect on the class that is chosen.
- R3: If the map entry for the region is class 0, no response is produced, whatever the action table holds for class 0. The ignored counter goes up by one. err_ready is low for exactly one cycle after the accepting edge.
- R4: An error whose class is not 0 produces a rsp_valid pulse exactly one cycle long. The pulse is visible in the cycle after the second clock edge following the accepting edge. The response carries the region's class, the table's action code for that class, and the error's frame and offset.
- R5: After an error whose class is not 0 is accepted, err_ready is low for exactly two cycles. No report is taken while err_ready is low.
- R6: A write with map_we=1 and map_sel=1 stores map_wdata[1:0] as the action code for class map_addr. The codes are: 00 none, 01 log only, 10 reset region, 11 full reconfigure. Each class keeps its own code.
- R7: A write with map_we=1 and map_sel=0 stores map_wdata as the class of region map_addr. The new class applies to every report accepted after that write cycle.
- R8: cnt_acted goes up by one with each response. cnt_ignored goes up by one with each dropped error. Both counters stop at all-ones.
- R9: While err_valid is low, no report is taken, no response appears and the counters do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | Error report offered |
| err_ready | output | 1 | Classifier can take a report |
| err_frame | input | FRAME_W | Frame index of the upset |
| err_offset | input | OFFSET_W | Bit offset of the upset inside the frame |
| map_we | input | 1 | Table write strobe |
| map_sel | input | 1 | 0 selects the region map, 1 selects the action table |
| map_addr | input | MADDR_W | Region or class being written |
| map_wdata | input | CLASS_W | Class value, or action code in bits 1:0 |
| rsp_valid | output | 1 | One-cycle recovery response |
| rsp_class | output | CLASS_W | Class of the affected region |
| rsp_action | output | 2 | Recovery code |
| rsp_frame | output | FRAME_W | Frame of the error being answered |
| rsp_offset | output | OFFSET_W | Offset of the error being answered |
| cnt_ignored | output | CNT_W | Saturating count of dropped errors |
| cnt_acted | output | CNT_W | Saturating count of responses |

## Verification
The bench sends reports that differ only in their low frame bits and offsets, to catch a design that builds the map address from the wrong bits and so picks the wrong class. It sends unused-region errors while the action table holds a real code for class 0; a design that reads the table without first testing for class 0 would then issue a false recovery, or would keep err_ready low for a cycle too long. It rewrites map entries between reports, and it drives the counters with a narrow width until they must hold at all-ones; an off-by-one in the latency, stale map data or a counter that wraps each shows up as a mismatched response or count.

// File: rtl/seu_lookup_pkg.sv
package seu_lookup_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MAP  = 2'd1,
        ST_ACT  = 2'd2
    } lkp_state_e;

    localparam int ACT_W = 2;

    localparam logic [ACT_W-1:0] ACT_NONE     = 2'b00;
    localparam logic [ACT_W-1:0] ACT_LOG      = 2'b01;
    localparam logic [ACT_W-1:0] ACT_RST_RGN  = 2'b10;
    localparam logic [ACT_W-1:0] ACT_RECONFIG = 2'b11;

endpackage

// File: rtl/seu_sync_ram.sv
module seu_sync_ram #(
    parameter int DW = 8,
    parameter int AW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Read-before-write when the read and write addresses are the same
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/seu_sat_counter.sv
module seu_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != '1)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/seu_class_lookup.sv
module seu_class_lookup
    import seu_lookup_pkg::*;
#(
    parameter int FRAME_W  = 12,
    parameter int OFFSET_W = 16,
    parameter int REGION_W = 8,
    parameter int CLASS_W  = 8,
    parameter int CNT_W    = 16,
    localparam int MADDR_W = (REGION_W > CLASS_W) ? REGION_W : CLASS_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                err_valid,
    output logic                err_ready,
    input  logic [FRAME_W-1:0]  err_frame,
    input  logic [OFFSET_W-1:0] err_offset,
    input  logic                map_we,
    input  logic                map_sel,
    input  logic [MADDR_W-1:0]  map_addr,
    input  logic [CLASS_W-1:0]  map_wdata,
    output logic                rsp_valid,
    output logic [CLASS_W-1:0]  rsp_class,
    output logic [ACT_W-1:0]    rsp_action,
    output logic [FRAME_W-1:0]  rsp_frame,
    output logic [OFFSET_W-1:0] rsp_offset,
    output logic [CNT_W-1:0]    cnt_ignored,
    output logic [CNT_W-1:0]    cnt_acted
);
    typedef struct packed {
        lkp_state_e          st;
        logic [FRAME_W-1:0]  frame;
        logic [OFFSET_W-1:0] offset;
        logic [CLASS_W-1:0]  cls;
        logic [ACT_W-1:0]    act;
        logic                rsp_v;
    } lkp_regs_t;

    lkp_regs_t r_d, r_q;

    logic                map_re, act_re;
    logic [REGION_W-1:0] map_raddr;
    logic [CLASS_W-1:0]  map_rdata;
    logic [ACT_W-1:0]    act_rdata;
    logic                inc_ign, inc_act;
    logic                rgn_we, act_we;

    assign rgn_we    = map_we && !map_sel;
    assign act_we    = map_we && map_sel;
    assign map_raddr = err_frame[FRAME_W-1 -: REGION_W];

    seu_sync_ram #(.DW(CLASS_W), .AW(REGION_W)) u_region_map (
        .clk   (clk),
        .we    (rgn_we),
        .waddr (map_addr[REGION_W-1:0]),
        .wdata (map_wdata),
        .re    (map_re),
        .raddr (map_raddr),
        .rdata (map_rdata)
    );

    seu_sync_ram #(.DW(ACT_W), .AW(CLASS_W)) u_action_tbl (
        .clk   (clk),
        .we    (act_we),
        .waddr (map_addr[CLASS_W-1:0]),
        .wdata (map_wdata[ACT_W-1:0]),
        .re    (act_re),
        .raddr (map_rdata),
        .rdata (act_rdata)
    );

    always_comb begin
        r_d       = r_q;
        r_d.rsp_v = 1'b0;
        map_re    = 1'b0;
        act_re    = 1'b0;
        inc_ign   = 1'b0;
        inc_act   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (err_valid) begin
                    map_re     = 1'b1;
                    r_d.frame  = err_frame;
                    r_d.offset = err_offset;
                    r_d.st     = ST_MAP;
                end
            end
            ST_MAP: begin
                r_d.cls = map_rdata;
                if (map_rdata == '0) begin
                    // Unused region: drop without a response
                    inc_ign = 1'b1;
                    r_d.st  = ST_IDLE;
                end else begin
                    act_re = 1'b1;
                    r_d.st = ST_ACT;
                end
            end
            ST_ACT: begin
                r_d.act   = act_rdata;
                r_d.rsp_v = 1'b1;
                inc_act   = 1'b1;
                r_d.st    = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;
            r_q.frame  <= '0;
            r_q.offset <= '0;
            r_q.cls    <= '0;
            r_q.act    <= ACT_NONE;
            r_q.rsp_v  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    seu_sat_counter #(.W(CNT_W)) u_cnt_ign (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (inc_ign),
        .count (cnt_ignored)
    );

    seu_sat_counter #(.W(CNT_W)) u_cnt_act (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (inc_act),
        .count (cnt_acted)
    );

    assign err_ready  = (r_q.st == ST_IDLE);
    assign rsp_valid  = r_q.rsp_v;
    assign rsp_class  = r_q.cls;
    assign rsp_action = r_q.act;
    assign rsp_frame  = r_q.frame;
    assign rsp_offset = r_q.offset;
endmodule

// File: rtl/seu_class_lookup_chk.sv
module seu_class_lookup_chk #(
    parameter int CLASS_W = 8,
    parameter int CNT_W   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               err_valid,
    input logic               err_ready,
    input logic               rsp_valid,
    input logic [CLASS_W-1:0] rsp_class,
    input logic [CNT_W-1:0]   cnt_ignored,
    input logic [CNT_W-1:0]   cnt_acted
);
    // R4
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R5
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && err_ready) |=> !err_ready);

    // R5
    rsp_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !$past(err_ready));

    // R3
    no_rsp_for_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_class != '0));

    // R8
    acted_tracks_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && ($past(cnt_acted) != '1)) |-> (cnt_acted == $past(cnt_acted) + 1'b1));

    // R8
    ignored_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_ignored != '1) |=> (cnt_ignored >= $past(cnt_ignored)));

    // R9
    idle_counters_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ready && !err_valid) |=> $stable(cnt_ignored));
endmodule

bind seu_class_lookup seu_class_lookup_chk #(.CLASS_W(CLASS_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_valid   (err_valid),
    .err_ready   (err_ready),
    .rsp_valid   (rsp_valid),
    .rsp_class   (rsp_class),
    .cnt_ignored (cnt_ignored),
    .cnt_acted   (cnt_acted)
);

// File: tb/sim_seu_class_lookup.sv
module sim_seu_class_lookup;
    localparam int FW = 12;
    localparam int OW = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          err_valid = 1'b0;
    logic          err_ready;
    logic [FW-1:0] err_frame = '0;
    logic [OW-1:0] err_offset = '0;
    logic          map_we = 1'b0;
    logic          map_sel = 1'b0;
    logic [7:0]    map_addr = '0;
    logic [7:0]    map_wdata = '0;
    logic          rsp_valid;
    logic [7:0]    rsp_class;
    logic [1:0]    rsp_action;
    logic [FW-1:0] rsp_frame;
    logic [OW-1:0] rsp_offset;
    logic [CW-1:0] cnt_ignored, cnt_acted;

    seu_class_lookup #(.FRAME_W(FW), .OFFSET_W(OW), .REGION_W(8), .CLASS_W(8), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_ready(err_ready),
        .err_frame(err_frame), .err_offset(err_offset), .map_we(map_we),
        .map_sel(map_sel), .map_addr(map_addr), .map_wdata(map_wdata),
        .rsp_valid(rsp_valid), .rsp_class(rsp_class), .rsp_action(rsp_action),
        .rsp_frame(rsp_frame), .rsp_offset(rsp_offset),
        .cnt_ignored(cnt_ignored), .cnt_acted(cnt_acted)
    );

    always #5 clk = ~clk;

    typedef struct {
        int            cyc;
        logic [7:0]    cls;
        logic [1:0]    act;
        logic [FW-1:0] frame;
        logic [OW-1:0] off;
    } exp_t;

    exp_t          exp_q[$];
    logic [7:0]    map_m [256];
    logic [1:0]    act_m [256];
    int            cyc = 0;
    int            n_chk = 0;
    int            n_fail = 0;
    int            exp_ign = 0;
    int            exp_act = 0;
    localparam int CMAX = (1 << CW) - 1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint actv, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actv, expv);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Monitor: pop and compare each response
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9", "unexpected response, class", rsp_class, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(cyc == e.cyc, "R4", "response cycle", cyc, e.cyc);
                chk(rsp_class == e.cls, "R2", "class", rsp_class, e.cls);
                chk(rsp_action == e.act, "R6", "action", rsp_action, e.act);
                chk(rsp_frame == e.frame, "R4", "frame echo", rsp_frame, e.frame);
                chk(rsp_offset == e.off, "R4", "offset echo", rsp_offset, e.off);
            end
        end
    end

    task automatic wr(input bit sel, input logic [7:0] a, input logic [7:0] d);
        map_we = 1'b1; map_sel = sel; map_addr = a; map_wdata = d;
        if (sel) act_m[a] = d[1:0]; else map_m[a] = d;
        @(negedge clk);
        map_we = 1'b0;
    endtask

    task automatic send(input logic [FW-1:0] fr, input logic [OW-1:0] off);
        int acc;
        logic [7:0] c;
        err_valid = 1'b1; err_frame = fr; err_offset = off;
        while (!err_ready) @(negedge clk);
        acc = cyc + 1;
        c = map_m[fr[11:4]];
        if (c != 0) begin
            exp_q.push_back('{acc + 2, c, act_m[c], fr, off});
            if (exp_act < CMAX) exp_act++;
        end else begin
            if (exp_ign < CMAX) exp_ign++;
        end
        @(negedge clk);
        err_valid = 1'b0;
        err_frame = ~fr; err_offset = ~off;
        chk(!err_ready, "R5", "ready after accept", err_ready, 0);
        @(negedge clk);
        if (c == 0) chk(err_ready, "R3", "ready after drop", err_ready, 1);
        else        chk(!err_ready, "R5", "ready second busy cycle", err_ready, 0);
        if (c != 0) begin
            @(negedge clk);
            chk(err_ready, "R5", "ready after response", err_ready, 1);
        end
        chk(cnt_ignored == exp_ign[CW-1:0], "R8", "ignored count", cnt_ignored, exp_ign);
        chk(cnt_acted == exp_act[CW-1:0], "R8", "acted count", cnt_acted, exp_act);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(err_ready, "R1", "reset ready", err_ready, 1);
        chk(!rsp_valid, "R1", "reset rsp_valid", rsp_valid, 0);
        chk(cnt_ignored == 0, "R1", "reset ignored", cnt_ignored, 0);
        chk(cnt_acted == 0, "R1", "reset acted", cnt_acted, 0);

        for (int i = 0; i < 256; i++) wr(1'b0, i[7:0], 8'd0);
        for (int i = 0; i < 256; i++) wr(1'b1, i[7:0], 8'd0);

        // R6: action codes per class, class 0 given a real code anyway
        wr(1'b1, 8'd5,   8'h01);
        wr(1'b1, 8'd9,   8'h02);
        wr(1'b1, 8'd200, 8'hFF);
        wr(1'b1, 8'd255, 8'h01);
        wr(1'b1, 8'd0,   8'h03);
        // R7: region classes
        wr(1'b0, 8'd3,   8'd5);
        wr(1'b0, 8'd4,   8'd9);
        wr(1'b0, 8'hFF,  8'd200);
        wr(1'b0, 8'd0,   8'd255);

        // R2: same region, varying low frame bits and offset
        send(12'h030, 16'h0000);
        send(12'h03F, 16'hFFFF);
        send(12'h037, 16'h1234);
        send(12'h040, 16'h0042);
        send(12'hFF5, 16'hBEEF);
        send(12'h00A, 16'h0001);
        // R3: unused regions dropped even though class 0 has a code
        send(12'h0A3, 16'h0777);
        send(12'h555, 16'h0808);

        // R7: reclassify region 4 and region 0x0A, then resend
        wr(1'b0, 8'd4,  8'd200);
        send(12'h041, 16'h0100);
        wr(1'b0, 8'h0A, 8'd9);
        send(12'h0AC, 16'h0200);
        wr(1'b0, 8'd3,  8'd0);
        send(12'h031, 16'h0300);
        // R6: change one class code, others unaffected
        wr(1'b1, 8'd9, 8'h03);
        send(12'h0A0, 16'h0400);
        send(12'h042, 16'h0500);

        // R9: no valid, inputs wiggle
        begin
            logic [CW-1:0] ig, ac;
            ig = cnt_ignored; ac = cnt_acted;
            for (int i = 0; i < 10; i++) begin
                err_frame = 12'h040 + i[11:0]; err_offset = i[15:0];
                @(negedge clk);
                chk(err_ready, "R9", "ready while idle", err_ready, 1);
            end
            chk(cnt_ignored == ig, "R9", "ignored stable", cnt_ignored, ig);
            chk(cnt_acted == ac, "R9", "acted stable", cnt_acted, ac);
        end

        // R8: saturation of both counters
        for (int i = 0; i < 20; i++) send(12'h040 + i[11:0] % 16, i[15:0]);
        for (int i = 0; i < 20; i++) send(12'h300 + i[11:0], i[15:0]);
        chk(cnt_acted == CMAX[CW-1:0], "R8", "acted saturated", cnt_acted, CMAX);
        chk(cnt_ignored == CMAX[CW-1:0], "R8", "ignored saturated", cnt_ignored, CMAX);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R4", "responses outstanding", exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule